// File: doc/BRIEF.md
# Keyboard Serial Link Transceiver

This block is a full-duplex asynchronous serial port for the link to a keyboard. It sits behind a single byte-wide data register. A write to the register hands the byte to the transmitter, which sends it as a framed character on `txd`. A read returns the most recent character taken from `rxd`. Two level flags, `tx_empty` and `rx_full`, go to a separate interrupt controller. That controller does any masking; this block does none.

The bit rate comes from a 16-bit reload value N. The input clock is first divided by 8 and then by N+1, which gives a tick at sixteen times the bit rate. One bit therefore lasts 128·(N+1) clock cycles. The reset value of N is 1, which gives 31250 baud from an 8 MHz input clock. Software loads a new N through `div_wr`/`div_data`. The load restarts the divider chain at once.

The receiver samples `rxd` on every tick through a two-stage synchroniser. It checks that a start bit is still low halfway through that bit, and it samples each data bit near its centre. A character whose first stop bit is seen low is thrown away.

Top module: `kbd_serial_port`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, `rx_full` is 0 and `rd_data` is 0x00.
- R2: A transmitted frame has eleven bits, each 128·(N+1) clock cycles long. The first is a start bit (0). Next come the eight data bits, least significant bit first. Last are two stop bits (1). When no frame is being sent, `txd` stays at 1.
- R3: When `wr_en` is high and `tx_empty` is 1 at a clock edge, after that edge `tx_empty` is 0 and `txd` is 0 (the start bit).
- R4: `tx_empty` returns to 1 at the end of the second stop bit, and not before.
- R5: A write while `tx_empty` is 0 is ignored. The frame in progress goes out unchanged, and no further frame follows it.
- R6: When a frame with a valid first stop bit (1) has been received, its byte appears on `rd_data` and `rx_full` is set. A later frame overwrites the byte.
- R7: A cycle with `rd_en` high clears `rx_full` on the next edge and leaves `rd_data` unchanged. If a new character arrives in the same cycle, setting `rx_full` takes priority.
- R8: A frame whose first stop bit is 0 is discarded. `rd_data` and `rx_full` keep their previous values.
- R9: A low pulse on `rxd` that does not last until the middle of a bit time starts no frame. The receiver stays ready for the next real start bit.
- R10: N resets to 1. A pulse on `div_wr` loads `div_data` as the new N, and the bit length changes to 128·(N+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data register write strobe; starts a transmission |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Data register read strobe; clears `rx_full` |
| rd_data | output | 8 | Last byte received |
| div_wr | input | 1 | Load strobe for the rate divider |
| div_data | input | 16 | New divider reload value N |
| rxd | input | 1 | Serial input from the keyboard |
| txd | output | 1 | Serial output to the keyboard |
| rx_full | output | 1 | A received byte is waiting |
| tx_empty | output | 1 | Transmitter idle and ready for a byte |

## Verification
The transmitter is tested with several byte patterns: 0x00, 0x55, 0x80, 0xFF and 0xA5. Alternating bits show whether the bit order is reversed. Single set or clear bits show off-by-one errors in the shift position. An all-zero byte, timed at two divider settings, measures the bit length against N. On the receive side, the tests send valid frames with distinct bytes, a frame with a bad stop bit (both when `rx_full` is clear and when it is set), and a short glitch. Together these separate correct capture from framing acceptance and from false-start rejection. A second write during a frame shows whether the frame in progress can be corrupted.

// File: rtl/kbd_serial_pkg.sv
package kbd_serial_pkg;
  localparam int KB_DATA_W    = 8;
  localparam int KB_STOP_BITS = 2;
  localparam int KB_OVS       = 16;
  localparam int KB_PRE_DIV   = 8;
  localparam int KB_DIV_W     = 16;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;
endpackage

// File: rtl/kbd_baud_gen.sv
module kbd_baud_gen #(
  parameter int              PRE_DIV  = 8,
  parameter int              DIV_W    = 16,
  parameter logic [DIV_W-1:0] DIV_INIT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DIV_W-1:0] value_i,
  output logic             tick_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] reload_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      reload_q <= DIV_INIT;
      cnt_q    <= DIV_INIT;
      tick_q   <= 1'b0;
    end else if (load_i) begin
      pre_q    <= '0;
      reload_q <= value_i;
      cnt_q    <= value_i;
      tick_q   <= 1'b0;
    end else begin
      tick_q <= pre_wrap && (cnt_q == '0);
      pre_q  <= pre_wrap ? '0 : pre_q + 1'b1;
      if (pre_wrap) begin
        cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      end
    end
  end

  assign tick_o = tick_q;

  generate
    if (PRE_DIV > 1) begin : g_gap_chk
      // R10: the prescaler keeps ticks at least PRE_DIV cycles apart
      p_tick_gap_r10: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/kbd_tx.sv
module kbd_tx #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2,
  parameter int OVS       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              empty_o
);
  localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
  localparam int CNT_W   = $clog2(OVS);
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shift_q;
  logic               busy_q;
  logic [CNT_W-1:0]   tcnt_q;
  logic [BIT_W-1:0]   bidx_q;
  logic               txd_q;
  logic               empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '1;
      busy_q  <= 1'b0;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      txd_q   <= 1'b1;
      empty_q <= 1'b1;
    end else if (!busy_q) begin
      if (start_i) begin
        // bits still to go after the start bit: data, stops, one pad bit
        shift_q <= {{(STOP_BITS + 1){1'b1}}, data_i};
        busy_q  <= 1'b1;
        tcnt_q  <= '0;
        bidx_q  <= '0;
        txd_q   <= 1'b0;
        empty_q <= 1'b0;
      end
    end else if (tick_i) begin
      if (tcnt_q == CNT_LAST) begin
        tcnt_q <= '0;
        if (bidx_q == BIT_LAST) begin
          busy_q  <= 1'b0;
          empty_q <= 1'b1;
          txd_q   <= 1'b1;
        end else begin
          bidx_q  <= bidx_q + 1'b1;
          txd_q   <= shift_q[0];
          shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign txd_o   = txd_q;
  assign empty_o = empty_q;

  // R2: the line rests high whenever no frame is in flight
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);

  // R4: ready is raised only as a stop bit finishes
  p_empty_on_stop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_q) |-> $past(txd_q) && $past(tick_i));
endmodule

// File: rtl/kbd_rx.sv
module kbd_rx
  import kbd_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              done_o
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0]  CNT_HALF  = CNT_W'(OVS / 2 - 1);
  localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(DATA_W - 1);

  logic              s1_q, s2_q;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIDX_W-1:0] bidx_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] byte_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!s2_q) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CNT_HALF) begin
              cnt_q  <= '0;
              bidx_q <= '0;
              state_q <= s2_q ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {s2_q, sh_q[DATA_W-1:1]};
              if (bidx_q == BIDX_LAST) state_q <= RX_STOP;
              else bidx_q <= bidx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              if (s2_q) begin
                byte_q  <= sh_q;
                done_q  <= 1'b1;
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_WAIT_HIGH;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_WAIT_HIGH: begin
            if (s2_q) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = byte_q;
  assign done_o = done_q;

  // R8: a byte is delivered only after a high first stop bit
  p_good_stop_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(s2_q) && ($past(state_q) == RX_STOP));

  // R9: a line that is high again at mid start bit returns to idle
  p_false_start_r9: assert property (@(posedge clk) disable iff (rst)
    (tick_i && state_q == RX_START && cnt_q == CNT_HALF && s2_q) |=> state_q == RX_IDLE);
endmodule

// File: rtl/kbd_serial_port.sv
module kbd_serial_port
  import kbd_serial_pkg::*;
#(
  parameter int                DATA_W    = KB_DATA_W,
  parameter int                STOP_BITS = KB_STOP_BITS,
  parameter int                OVS       = KB_OVS,
  parameter int                PRE_DIV   = KB_PRE_DIV,
  parameter int                DIV_W     = KB_DIV_W,
  parameter logic [DIV_W-1:0]  DIV_INIT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_data,
  input  logic              rxd,
  output logic              txd,
  output logic              rx_full,
  output logic              tx_empty
);
  logic              tick;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_done;
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  kbd_baud_gen #(
    .PRE_DIV (PRE_DIV),
    .DIV_W   (DIV_W),
    .DIV_INIT(DIV_INIT)
  ) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load_i (div_wr),
    .value_i(div_data),
    .tick_o (tick)
  );

  kbd_tx #(
    .DATA_W   (DATA_W),
    .STOP_BITS(STOP_BITS),
    .OVS      (OVS)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .start_i(wr_en),
    .data_i (wr_data),
    .txd_o  (txd),
    .empty_o(tx_empty)
  );

  kbd_rx #(
    .DATA_W(DATA_W),
    .OVS   (OVS)
  ) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick_i(tick),
    .rxd_i (rxd),
    .byte_o(rx_byte),
    .done_o(rx_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (rx_done) begin
      data_q <= rx_byte;
      full_q <= 1'b1;
    end else if (rd_en) begin
      full_q <= 1'b0;
    end
  end

  assign rd_data = data_q;
  assign rx_full = full_q;

  // R3: an accepted write drops ready and drives the start bit
  p_wr_starts_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en && tx_empty |=> !tx_empty && !txd);

  // R7: a read with no new arrival clears the full flag
  p_rd_clears_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rx_done |=> !rx_full);

  // R6: a delivered byte always leaves the flag set
  p_arrival_sets_r6: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_full && (rd_data == $past(rx_byte)));
endmodule

// File: tb/sim_kbd_serial_port.sv
module sim_kbd_serial_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        div_wr = 1'b0;
  logic [15:0] div_data = '0;
  logic        rxd = 1'b1;
  logic        txd;
  logic        rx_full;
  logic        tx_empty;

  int n_chk = 0;
  int n_fail = 0;
  int bitp = 256;   // clock cycles per bit for the current N
  int tickp = 16;   // clock cycles per oversample tick

  always #10 clk = ~clk;

  kbd_serial_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .div_wr(div_wr), .div_data(div_data), .rxd(rxd),
    .txd(txd), .rx_full(rx_full), .tx_empty(tx_empty)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_div(input int n);
    @(negedge clk); div_wr = 1'b1; div_data = 16'(n);
    @(negedge clk); div_wr = 1'b0;
    bitp = 128 * (n + 1);
    tickp = 8 * (n + 1);
  endtask

  // samples a frame whose start bit began at the last write edge
  task automatic capture(output logic st, output logic [7:0] d, output logic [1:0] sp);
    wait_clk(bitp / 2);
    st = txd;
    for (int i = 0; i < 8; i++) begin wait_clk(bitp); d[i] = txd; end
    for (int i = 0; i < 2; i++) begin wait_clk(bitp); sp[i] = txd; end
  endtask

  task automatic t_reset;
    check("R1", "txd after reset", int'(txd), 1);
    check("R1", "tx_empty after reset", int'(tx_empty), 1);
    check("R1", "rx_full after reset", int'(rx_full), 0);
    check("R1", "rd_data after reset", int'(rd_data), 0);
  endtask

  task automatic t_bit_length(input string req);
    int low = 0;
    do_write(8'h00);
    while (txd == 1'b0 && low < 20 * bitp) begin @(negedge clk); low++; end
    // start plus eight zero bits; first bit may lose up to one tick
    check_rng(req, "low time of 0x00 frame", low + 1, 9 * bitp - tickp - 2, 9 * bitp + 2);
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic t_tx(input logic [7:0] b);
    logic st; logic [7:0] d; logic [1:0] sp;
    do_write(b);
    check("R3", "tx_empty after write", int'(tx_empty), 0);
    check("R3", "txd after write", int'(txd), 0);
    capture(st, d, sp);
    check("R2", "start bit", int'(st), 0);
    check("R2", "data bits", int'(d), int'(b));
    check("R2", "stop bits", int'(sp), 3);
    check("R4", "tx_empty mid second stop", int'(tx_empty), 0);
    wait_clk(bitp / 2 + tickp + 4);
    check("R4", "tx_empty after frame", int'(tx_empty), 1);
  endtask

  task automatic t_tx_busy;
    logic st; logic [7:0] d; logic [1:0] sp;
    int lows = 0;
    do_write(8'hA5);
    fork
      capture(st, d, sp);
      begin wait_clk(3 * bitp); do_write(8'h3C); end
    join
    check("R5", "frame unchanged by write while busy", int'(d), 8'hA5);
    wait_clk(bitp / 2 + tickp + 4);
    check("R5", "tx_empty after busy frame", int'(tx_empty), 1);
    for (int i = 0; i < 2 * bitp; i++) begin @(negedge clk); if (!txd) lows++; end
    check("R5", "no second frame follows", lows, 0);
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic stop1);
    logic [10:0] f;
    f = {1'b1, stop1, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = f[i];
      wait_clk(bitp);
    end
    rxd = 1'b1;
    wait_clk(4);
  endtask

  task automatic t_rx(input logic [7:0] b);
    rx_frame(b, 1'b1);
    check("R6", "rx_full after frame", int'(rx_full), 1);
    check("R6", "rd_data after frame", int'(rd_data), int'(b));
  endtask

  task automatic t_read(input logic [7:0] keep);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R7", "rx_full after read", int'(rx_full), 0);
    check("R7", "rd_data after read", int'(rd_data), int'(keep));
  endtask

  task automatic t_bad_stop(input logic [7:0] b, input logic full_before, input logic [7:0] keep);
    rx_frame(b, 1'b0);
    check("R8", "rx_full after bad stop", int'(rx_full), int'(full_before));
    check("R8", "rd_data after bad stop", int'(rd_data), int'(keep));
  endtask

  task automatic t_glitch(input logic [7:0] keep);
    @(negedge clk); rxd = 1'b0;
    wait_clk(bitp / 4);
    rxd = 1'b1;
    wait_clk(2 * bitp);
    check("R9", "rx_full after glitch", int'(rx_full), 0);
    check("R9", "rd_data after glitch", int'(rd_data), int'(keep));
    rx_frame(8'h96, 1'b1);
    check("R9", "frame after glitch received", int'(rd_data), 8'h96);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_bit_length("R10");          // default N=1: 256 cycles per bit
    set_div(0);
    t_bit_length("R10");          // N=0: 128 cycles per bit
    t_tx(8'h55);
    t_tx(8'h80);
    t_tx(8'hFF);
    t_tx_busy();
    t_rx(8'hA5);
    t_rx(8'h01);                  // overwrite without a read
    t_read(8'h01);
    t_bad_stop(8'h5A, 1'b0, 8'h01);
    t_rx(8'h33);
    t_bad_stop(8'h77, 1'b1, 8'h33);
    t_read(8'h33);
    t_glitch(8'h33);
    t_read(8'h96);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_clk(150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule